// File: doc/BRIEF.md
# Serial Access Buffer Port

This block is the serial side of a dual-ported DRAM: a 256-word by 8-bit static buffer placed next to a small array of rows. A transfer command moves data between a chosen array row and the buffer, in either direction. It can move the whole row or only one half. A full transfer also loads the serial pointer with a start tap. After that, the buffer streams words out, or takes words in, one word per serial clock enable pulse.

In split mode only the half the pointer is not in (the idle half) is transferred. The pointer keeps counting through the active half, so software can reload one half while the other half streams. A flag output gives the pointer's current half. The array is a behavioural row model. At reset its rows are filled with a computed pattern.

The serial data bus is split into an output stream and an input stream, each with valid/ready. The serial clock enable paces both streams. On the output stream, a word is presented only during an enable pulse. Holding `so_ready` low stalls the pointer on that pulse. The input stream takes no back-pressure from the sender: `si_ready` only shows when a word would be stored.

Top module: `sam_port`

## Requirements
- R1: After reset the pointer is 0, the serial direction is output, every buffer word is 0 and `half_flag` is 0. Array row r, column c holds (53*r + c) mod 256.
- R2: A full load transfer (`xfer_req`=1, `xfer_store`=0, `xfer_split`=0) copies the whole selected row into the buffer, sets the pointer to `xfer_tap` and selects output direction. All of this is visible from the next cycle.
- R3: In output direction, `so_valid` = `port_en` & `sclk_en` and `so_data` is the buffer word at the pointer. If `so_ready` is low during such a pulse, the pointer holds.
- R4: Each serial step advances the pointer by one, wrapping from 255 to 0.
- R5: A full store transfer (`xfer_store`=1, `xfer_split`=0) copies the buffer as it was before that edge into the selected row, sets the pointer to `xfer_tap` and selects input direction.
- R6: In input direction, `si_ready` = `port_en` & `sclk_en`. A word with `si_valid` & `si_ready` is written at the pointer. The pointer advances on every `sclk_en` pulse, with or without data.
- R7: With `port_en` low, `so_valid` and `si_ready` are 0 and no serial write occurs, but the pointer still advances on each `sclk_en` pulse.
- R8: A split load copies only the idle half of the row into the buffer. The idle half is the upper half (words 128..255) when pointer bit 7 is 0, otherwise the lower half. The active half and the pointer's normal stepping are unaffected.
- R9: A split store writes only the idle half of the buffer into the row. The row's other half is left unchanged.
- R10: `half_flag` equals pointer bit 7. It updates in the cycle after a serial step or a transfer.
- R11: In the cycle a transfer is issued, `so_data` still shows the old buffer contents. A full load overrides a serial write made in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| xfer_req | input | 1 | Transfer command, one cycle |
| xfer_store | input | 1 | 1: buffer to row, 0: row to buffer |
| xfer_split | input | 1 | Move only the idle half |
| xfer_row | input | 2 | Array row selected for the transfer |
| xfer_tap | input | 8 | Start pointer for full transfers |
| sclk_en | input | 1 | Serial clock enable pulse |
| port_en | input | 1 | Serial port enable |
| so_data | output | 8 | Output stream word |
| so_valid | output | 1 | Output word offered |
| so_ready | input | 1 | Output word taken |
| si_data | input | 8 | Input stream word |
| si_valid | input | 1 | Input word offered |
| si_ready | output | 1 | Input word would be stored |
| half_flag | output | 1 | Half the pointer is in |

## Verification
The bench goes after the pointer wrapping at 255 and starting from a tap near the top. A bad wrap would stream the wrong words after index 255. It checks split transfers around the 127/128 crossing. A design that picked the wrong idle half would overwrite words that are still streaming, or fail to deliver the new half when the pointer crosses. It also checks same-cycle collisions: a serial write against a full load, and a store against buffer writes. A design that got the priority wrong would leave a stray serial word in the buffer, or store data written in the same cycle. Finally, it stalls with `so_ready` low and gates with `port_en` low. A design that mishandled either would skip words or write while disabled.

// File: rtl/sam_pkg.sv
package sam_pkg;
  typedef enum logic {SER_OUT = 1'b0, SER_IN = 1'b1} ser_dir_e;

  // reset pattern of the row array
  function automatic int unsigned seed_word(int unsigned row, int unsigned col);
    return row * 53 + col;
  endfunction
endpackage

// File: rtl/sam_rowarray.sv
module sam_rowarray #(
  parameter int WW    = 8,
  parameter int DEPTH = 256,
  parameter int ROWS  = 4,
  localparam int RW   = $clog2(ROWS),
  localparam int HALF = DEPTH / 2
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [RW-1:0]       row,
  input  logic                wr_lo,
  input  logic                wr_hi,
  input  logic [DEPTH*WW-1:0] wr_row,
  output logic [DEPTH*WW-1:0] rd_row
);
  logic [WW-1:0] mem [ROWS][DEPTH];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int r = 0; r < ROWS; r++)
        for (int c = 0; c < DEPTH; c++)
          mem[r][c] <= WW'(sam_pkg::seed_word(r, c));
    end else begin
      for (int c = 0; c < DEPTH; c++)
        if ((c < HALF) ? wr_lo : wr_hi)
          mem[row][c] <= wr_row[c*WW +: WW];
    end
  end

  always_comb begin
    for (int c = 0; c < DEPTH; c++)
      rd_row[c*WW +: WW] = mem[row][c];
  end
endmodule

// File: rtl/sam_bufstore.sv
module sam_bufstore #(
  parameter int WW    = 8,
  parameter int DEPTH = 256,
  localparam int AW   = $clog2(DEPTH),
  localparam int HALF = DEPTH / 2
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                ld_lo,
  input  logic                ld_hi,
  input  logic [DEPTH*WW-1:0] ld_row,
  input  logic                wr_en,
  input  logic [AW-1:0]       wr_addr,
  input  logic [WW-1:0]       wr_data,
  input  logic [AW-1:0]       rd_addr,
  output logic [WW-1:0]       rd_data,
  output logic [DEPTH*WW-1:0] all_data
);
  for (genvar g = 0; g < DEPTH; g++) begin : g_word
    logic          sel;
    logic [WW-1:0] q;
    assign sel = (g < HALF) ? ld_lo : ld_hi;
    // a transfer into a word beats a serial write to it
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                              q <= '0;
      else if (sel)                            q <= ld_row[g*WW +: WW];
      else if (wr_en && wr_addr == AW'(g))     q <= wr_data;
    end
    assign all_data[g*WW +: WW] = q;
  end

  assign rd_data = all_data[rd_addr*WW +: WW];
endmodule

// File: rtl/sam_ptr.sv
module sam_ptr #(
  parameter int AW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          jump,
  input  logic [AW-1:0] jump_addr,
  input  logic          step,
  output logic [AW-1:0] ptr
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    ptr <= '0;
    else if (jump) ptr <= jump_addr;
    else if (step) ptr <= ptr + 1'b1;
  end
endmodule

// File: rtl/sam_port.sv
module sam_port #(
  parameter int WW    = 8,
  parameter int DEPTH = 256,
  parameter int ROWS  = 4,
  localparam int AW   = $clog2(DEPTH),
  localparam int RW   = $clog2(ROWS)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          xfer_req,
  input  logic          xfer_store,
  input  logic          xfer_split,
  input  logic [RW-1:0] xfer_row,
  input  logic [AW-1:0] xfer_tap,
  input  logic          sclk_en,
  input  logic          port_en,
  output logic [WW-1:0] so_data,
  output logic          so_valid,
  input  logic          so_ready,
  input  logic [WW-1:0] si_data,
  input  logic          si_valid,
  output logic          si_ready,
  output logic          half_flag
);
  import sam_pkg::*;

  ser_dir_e            mode_q;
  logic [AW-1:0]       ptr;
  logic                step, full, idle_hi;
  logic                ld_lo, ld_hi, st_lo, st_hi, wr_en;
  logic [DEPTH*WW-1:0] row_rd, buf_all;

  assign full    = xfer_req & ~xfer_split;
  assign idle_hi = ~ptr[AW-1];
  assign step    = sclk_en & ((mode_q == SER_IN) | ~port_en | so_ready);

  assign ld_lo = xfer_req & ~xfer_store & (~xfer_split | ~idle_hi);
  assign ld_hi = xfer_req & ~xfer_store & (~xfer_split |  idle_hi);
  assign st_lo = xfer_req &  xfer_store & (~xfer_split | ~idle_hi);
  assign st_hi = xfer_req &  xfer_store & (~xfer_split |  idle_hi);

  assign so_valid  = port_en & sclk_en & (mode_q == SER_OUT);
  assign si_ready  = port_en & sclk_en & (mode_q == SER_IN);
  assign wr_en     = si_valid & si_ready;
  assign half_flag = ptr[AW-1];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        mode_q <= SER_OUT;
    else if (xfer_req) mode_q <= xfer_store ? SER_IN : SER_OUT;
  end

  sam_ptr #(.AW(AW)) i_ptr (
    .clk, .rst_n, .jump(full), .jump_addr(xfer_tap), .step, .ptr
  );

  sam_bufstore #(.WW(WW), .DEPTH(DEPTH)) i_buf (
    .clk, .rst_n, .ld_lo, .ld_hi, .ld_row(row_rd),
    .wr_en, .wr_addr(ptr), .wr_data(si_data),
    .rd_addr(ptr), .rd_data(so_data), .all_data(buf_all)
  );

  sam_rowarray #(.WW(WW), .DEPTH(DEPTH), .ROWS(ROWS)) i_arr (
    .clk, .rst_n, .row(xfer_row), .wr_lo(st_lo), .wr_hi(st_hi),
    .wr_row(buf_all), .rd_row(row_rd)
  );
endmodule

// File: rtl/sam_port_chk.sv
module sam_port_chk #(
  parameter int AW = 8
) (
  input logic          clk,
  input logic          rst_n,
  input logic          xfer_req,
  input logic          xfer_split,
  input logic [AW-1:0] xfer_tap,
  input logic          step,
  input logic [AW-1:0] ptr,
  input logic          port_en,
  input logic          so_valid,
  input logic          si_ready,
  input logic          half_flag
);
  // R4
  step_adv_chk: assert property (@(posedge clk) disable iff (!rst_n)
    step && !(xfer_req && !xfer_split) |=> ptr == AW'($past(ptr) + 1'b1));
  // R2
  tap_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
    xfer_req && !xfer_split |=> ptr == $past(xfer_tap));
  // R3
  ptr_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !step && !xfer_req |=> $stable(ptr));
  // R7
  port_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !port_en |-> !so_valid && !si_ready);
  // R10
  half_cross_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(half_flag) && !$past(xfer_req) |-> ptr == {1'b1, {(AW-1){1'b0}}});
endmodule

bind sam_port sam_port_chk #(.AW(AW)) i_chk (
  .clk, .rst_n, .xfer_req, .xfer_split, .xfer_tap, .step, .ptr,
  .port_en, .so_valid, .si_ready, .half_flag
);

// File: tb/test_sam_port.sv
module test_sam_port;
  localparam int CLK_P = 10;

  logic clk = 0, rst_n = 0;
  logic xfer_req = 0, xfer_store = 0, xfer_split = 0;
  logic [1:0] xfer_row = 0;
  logic [7:0] xfer_tap = 0;
  logic sclk_en = 0, port_en = 0, so_ready = 0, si_valid = 0;
  logic [7:0] si_data = 0;
  logic [7:0] so_data;
  logic so_valid, si_ready, half_flag;

  sam_port i_sam_port (.*);

  always #(CLK_P/2) clk = ~clk;

  int n_chk = 0, n_fail = 0;
  bit done = 0;
  string dtag = "R2";

  logic [7:0] m_buf [256];
  logic [7:0] m_arr [4][256];
  logic [7:0] m_ptr;
  bit m_in;

  task automatic chk(string tag, int act, int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  endtask

  function automatic bit exp_so_valid();
    return port_en && sclk_en && !m_in;
  endfunction

  function automatic bit exp_si_ready();
    return port_en && sclk_en && m_in;
  endfunction

  task automatic compare();
    chk("R3 so_valid", int'(so_valid), int'(exp_so_valid()));
    chk("R6 si_ready", int'(si_ready), int'(exp_si_ready()));
    chk("R10 half_flag", int'(half_flag), int'(m_ptr[7]));
    if (!m_in) chk({dtag, " so_data"}, int'(so_data), int'(m_buf[m_ptr]));
  endtask

  task automatic model_update();
    logic [7:0] nbuf [256];
    bit st, idle_hi;
    st = sclk_en && (m_in || !port_en || so_ready);
    idle_hi = !m_ptr[7];
    nbuf = m_buf;
    if (exp_si_ready() && si_valid) nbuf[m_ptr] = si_data;
    if (xfer_req)
      for (int c = 0; c < 256; c++)
        if (!xfer_split || ((c >= 128) == idle_hi)) begin
          if (xfer_store) m_arr[xfer_row][c] = m_buf[c];
          else            nbuf[c] = m_arr[xfer_row][c];
        end
    if (xfer_req && !xfer_split) m_ptr = xfer_tap;
    else if (st)                 m_ptr = m_ptr + 8'd1;
    if (xfer_req) m_in = xfer_store;
    m_buf = nbuf;
  endtask

  // inputs are set after a falling edge; this checks, clocks, and returns at the next falling edge
  task automatic tick();
    #1 compare();
    @(posedge clk);
    model_update();
    @(negedge clk);
  endtask

  task automatic drive(bit xr, bit xs, bit xsp, int row, int tap,
                       bit sc, bit pe, bit sr, bit sv, int sd);
    xfer_req = xr; xfer_store = xs; xfer_split = xsp;
    xfer_row = 2'(row); xfer_tap = 8'(tap);
    sclk_en = sc; port_en = pe; so_ready = sr; si_valid = sv; si_data = 8'(sd);
  endtask

  task automatic stream(int n);
    for (int i = 0; i < n; i++) begin
      drive(0, 0, 0, 0, 0, 1, 1, 1, 0, 0);
      tick();
    end
  endtask

  initial begin
    #(CLK_P * 200000);
    n_fail++;
    $display("FAIL watchdog actual=timeout expected=finish");
    finish_run();
  end

  initial begin
    for (int r = 0; r < 4; r++)
      for (int c = 0; c < 256; c++) m_arr[r][c] = 8'(r * 53 + c);
    for (int c = 0; c < 256; c++) m_buf[c] = 8'h00;
    m_ptr = 0; m_in = 0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);

    // R1: reset state
    drive(0, 0, 0, 0, 0, 1, 1, 0, 0, 0);
    #1;
    chk("R1 half_flag", int'(half_flag), 0);
    chk("R1 so_valid", int'(so_valid), 1);
    chk("R1 so_data", int'(so_data), 0);
    dtag = "R1";
    drive(1, 0, 0, 2, 0, 0, 1, 1, 0, 0); tick();
    stream(3);

    // R2 and R4: load near the top and wrap past 255
    dtag = "R2";
    drive(1, 0, 0, 1, 250, 0, 1, 1, 0, 0); tick();
    dtag = "R4";
    stream(10);

    // R3: stall with so_ready low
    dtag = "R3";
    for (int i = 0; i < 3; i++) begin drive(0, 0, 0, 0, 0, 1, 1, 0, 0, 0); tick(); end
    stream(2);

    // R7: port disabled, pointer still moves
    dtag = "R7";
    for (int i = 0; i < 4; i++) begin drive(0, 0, 0, 0, 0, 1, 0, 0, 0, 0); tick(); end
    stream(2);

    // R5 and R6: store, serial writes (some while disabled), store, reload
    drive(1, 1, 0, 3, 5, 0, 1, 1, 0, 0); tick();
    for (int i = 0; i < 8; i++) begin
      drive(0, 0, 0, 0, 0, 1, (i % 3) != 1, 0, 1, 8'hA0 + i); tick();
    end
    drive(0, 0, 0, 0, 0, 1, 1, 0, 0, 0); tick();
    drive(1, 1, 0, 3, 0, 0, 1, 1, 0, 0); tick();
    dtag = "R5";
    drive(1, 0, 0, 3, 0, 0, 1, 1, 0, 0); tick();
    stream(16);

    // R8: split load of the idle upper half, then cross 127/128
    dtag = "R8";
    drive(1, 0, 0, 0, 120, 0, 1, 1, 0, 0); tick();
    stream(4);
    drive(1, 0, 1, 2, 0, 1, 1, 1, 0, 0); tick();
    stream(8);

    // R9: split store of the idle upper half
    drive(1, 1, 0, 1, 0, 0, 1, 1, 0, 0); tick();
    for (int i = 0; i < 4; i++) begin drive(0, 0, 0, 0, 0, 1, 1, 0, 1, 8'h5A ^ i); tick(); end
    drive(1, 1, 1, 0, 0, 0, 1, 1, 0, 0); tick();
    dtag = "R9";
    drive(1, 0, 0, 0, 124, 0, 1, 1, 0, 0); tick();
    stream(8);

    // R11: same-cycle collisions
    dtag = "R11";
    drive(1, 0, 0, 1, 0, 1, 1, 1, 0, 0); tick();
    stream(2);
    drive(1, 1, 0, 2, 40, 0, 1, 1, 0, 0); tick();
    drive(1, 0, 0, 2, 40, 1, 1, 0, 1, 8'hEE); tick();
    stream(3);

    // random phase
    dtag = "R2";
    void'($urandom(32'h5A17));
    for (int i = 0; i < 3000; i++) begin
      drive(($urandom % 16) == 0, $urandom % 2, $urandom % 2, $urandom % 4,
            $urandom % 256, ($urandom % 4) != 0, ($urandom % 5) != 0,
            ($urandom % 4) != 0, $urandom % 2, $urandom % 256);
      tick();
    end

    finish_run();
  end
endmodule